// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer with Masked Register Writes

This block controls a successive-approximation converter that serves several analog channels. Software reaches it through a simple 32-bit register port. Every writable control word uses masked writes. The upper halfword of a written word says which bits of the lower halfword are taken. Bits whose mask bit is clear keep their previous value. As a result, software can change one field without first reading the register.

A conversion runs as follows. Software loads two delay counts: one for power-up settling and one for the sampling window. It arms the end-of-conversion interrupt. It then writes the conversion word with a channel number, the start bit and the single-shot bit. The sequencer works through these steps in turn:

1. It waits out the power-up delay.
2. It waits out the sampling window.
3. It runs a bit-serial binary search against an external comparator. The search drives a trial code out to the analog side and reads one "input is at or above the trial" bit back.
4. It stores the code in that channel's own result slot.
5. It raises a pending flag that software clears by writing a one.

The analog converter core sits outside this block. On the analog side the block provides only the channel select, the trial code and the comparator return.

Top module: `adcseq_top`

## Requirements
- R1: A write to the conversion word (0x000), power-up delay (0x004), sample window (0x00C), interrupt arm (0x104) or spare control word (0x108) updates bit n (n = 0..15) only when bit n+16 of the written data is 1. All other bits keep their value, and each of these registers reads back in bits 15:0.
- R2: In the conversion word, bits 2:0 hold the channel number, bit 4 is the start bit and bit 5 is the single-shot bit. The start bit is not stored and always reads as 0.
- R3: A start is taken only when the mask-enabled start bit is written as 1, the sequencer is idle, and the single-shot bit (after the write) is 1. Any other start write launches nothing. While a conversion runs, a second start changes neither the channel being converted nor its timing.
- R4: Status register 0x10C bit 0 reads 1 from the cycle after an accepted start until the result has been stored. It reads 0 when the sequencer is idle.
- R5: With P = max(delay at 0x004, 1) and S = max(window at 0x00C, 1), the interrupt output rises exactly P + S + 14 clock edges after the edge that takes the start write.
- R6: The stored result is the 12-bit unsigned code equal to the analog level, clamped to 4095. It is read at 0x120 + 4*k for channel k. No other channel's result changes. During a conversion the channel-select output shows the channel being converted.
- R7: Pending flag 0x110 bit 0 is set when a result is stored. A write with data bit 0 equal to 1 clears it, and a write with data bit 0 equal to 0 leaves it set.
- R8: The interrupt output is a register that follows (pending AND interrupt-arm bit 0) one cycle late.
- R9: A synchronous reset returns every register and every channel result to zero and drives the interrupt low.
- R10: Reads return data on the clock edge after the read request. Offsets that decode to no register, including result slots past the last channel, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data; upper halfword is the bit mask |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | End-of-conversion interrupt |
| ana_sel | output | CH_W | Analog channel select |
| dac_code | output | RES_W | Trial code presented to the comparator |
| cmp_hi | input | 1 | Comparator: analog level is at or above dac_code |

## Verification
The main sweep converts every channel against eight analog levels. The levels are zero, full scale, an over-range value, alternating-bit codes, a single LSB and the two codes either side of mid-scale. Each level exposes a different fault: a wrong polarity in the binary search, a missing clamp, or a wrong bit order. The delay counts cycle through values that include zero, which separates the one-cycle floor from an off-by-one in the counters. Each idle channel is held at a distinct level, so a wrong select or a misplaced result slot shows up as a wrong code in that slot. Further tests cover masked writes with partial masks, a restart while busy, a start with single-shot cleared, an unarmed interrupt, and a reset after results are present.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  // Register byte offsets (12-bit view; the top resizes them to ADDR_W)
  localparam logic [11:0] OFS_CONV   = 12'h000;
  localparam logic [11:0] OFS_PWRUP  = 12'h004;
  localparam logic [11:0] OFS_SAMPLE = 12'h00C;
  localparam logic [11:0] OFS_ARM    = 12'h104;
  localparam logic [11:0] OFS_SPARE  = 12'h108;
  localparam logic [11:0] OFS_STAT   = 12'h10C;
  localparam logic [11:0] OFS_PEND   = 12'h110;
  localparam logic [11:0] OFS_RES    = 12'h120;

  // Conversion-word fields
  localparam int GO_BIT     = 4;
  localparam int SINGLE_BIT = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_SAMPLE,
    ST_CONVERT,
    ST_STORE
  } seq_state_e;

  // Upper halfword of the write word enables the matching lower bits.
  function automatic logic [15:0] hw_masked(input logic [15:0] old_v,
                                            input logic [31:0] wd);
    return (old_v & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
  endfunction

endpackage

// File: rtl/adcseq_regs.sv
module adcseq_regs
  import adcseq_pkg::*;
#(
  parameter int CH_W   = 3,
  parameter int TW     = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              busy,
  input  logic              store_done,
  output logic              start_req,
  output logic [CH_W-1:0]   start_ch,
  output logic [TW-1:0]     pd_len,
  output logic [TW-1:0]     smp_len,
  output logic              irq_en,
  output logic              irq_pend,
  output logic [31:0]       rd_q
);

  localparam logic [ADDR_W-1:0] A_CONV   = ADDR_W'(OFS_CONV);
  localparam logic [ADDR_W-1:0] A_PWRUP  = ADDR_W'(OFS_PWRUP);
  localparam logic [ADDR_W-1:0] A_SAMPLE = ADDR_W'(OFS_SAMPLE);
  localparam logic [ADDR_W-1:0] A_ARM    = ADDR_W'(OFS_ARM);
  localparam logic [ADDR_W-1:0] A_SPARE  = ADDR_W'(OFS_SPARE);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFS_PEND);
  localparam logic [15:0]       GO_CLR   = ~(16'h1 << GO_BIT);

  logic [15:0] conv_q, pd_q, smp_q, arm_q, spare_q;
  logic        pend_q;
  logic [15:0] conv_new;
  logic [31:0] rd_mux;
  logic        wr_conv, wr_pd, wr_smp, wr_arm, wr_spare, wr_pend;

  assign wr_conv  = wr_en && (addr == A_CONV);
  assign wr_pd    = wr_en && (addr == A_PWRUP);
  assign wr_smp   = wr_en && (addr == A_SAMPLE);
  assign wr_arm   = wr_en && (addr == A_ARM);
  assign wr_spare = wr_en && (addr == A_SPARE);
  assign wr_pend  = wr_en && (addr == A_PEND);

  // Start bit is never stored: it acts once and reads back as zero.
  always_comb conv_new = hw_masked(conv_q, wdata) & GO_CLR;

  assign start_req = wr_conv && wdata[16+GO_BIT] && wdata[GO_BIT] &&
                     !busy && conv_new[SINGLE_BIT];
  assign start_ch  = conv_new[CH_W-1:0];
  assign pd_len    = pd_q[TW-1:0];
  assign smp_len   = smp_q[TW-1:0];
  assign irq_en    = arm_q[0];
  assign irq_pend  = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_q  <= '0;
      pd_q    <= '0;
      smp_q   <= '0;
      arm_q   <= '0;
      spare_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_conv)  conv_q  <= conv_new;
      if (wr_pd)    pd_q    <= hw_masked(pd_q, wdata);
      if (wr_smp)   smp_q   <= hw_masked(smp_q, wdata);
      if (wr_arm)   arm_q   <= hw_masked(arm_q, wdata);
      if (wr_spare) spare_q <= hw_masked(spare_q, wdata);
      if (store_done)                pend_q <= 1'b1;
      else if (wr_pend && wdata[0])  pend_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      A_CONV:   rd_mux = {16'h0, conv_q};
      A_PWRUP:  rd_mux = {16'h0, pd_q};
      A_SAMPLE: rd_mux = {16'h0, smp_q};
      A_ARM:    rd_mux = {16'h0, arm_q};
      A_SPARE:  rd_mux = {16'h0, spare_q};
      A_STAT:   rd_mux = {31'h0, busy};
      A_PEND:   rd_mux = {31'h0, pend_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
    else            rd_q <= '0;
  end

  // A write with an all-zero mask leaves the delay register unchanged.
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_pd && wdata[31:16] == 16'h0) |=> $stable(pd_q)); // R1

  // The pending flag is not dropped by a write whose bit 0 is 0.
  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !(wr_pend && wdata[0])) |=> pend_q); // R7

endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
  import adcseq_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int TW    = 16,
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [CH_W-1:0]  start_ch,
  input  logic [TW-1:0]    pd_len,
  input  logic [TW-1:0]    smp_len,
  input  logic             cmp_hi,
  output logic             busy,
  output logic [CH_W-1:0]  sel_ch,
  output logic [RES_W-1:0] dac_code,
  output logic             store_we,
  output logic [CH_W-1:0]  store_ch,
  output logic [RES_W-1:0] store_data
);

  localparam int BW = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [BW-1:0] TOP_BIT = BW'(RES_W - 1);

  seq_state_e       state_q;
  logic [TW-1:0]    cnt_q;
  logic [CH_W-1:0]  ch_q;
  logic [RES_W-1:0] code_q;
  logic [BW-1:0]    bit_q;
  logic [RES_W-1:0] trial;
  logic             pd_last, smp_last;

  assign trial    = code_q | (RES_W'(1) << bit_q);
  assign pd_last  = (pd_len == '0)  || (cnt_q == pd_len  - TW'(1));
  assign smp_last = (smp_len == '0) || (cnt_q == smp_len - TW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ch_q    <= '0;
      code_q  <= '0;
      bit_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_req) begin
            state_q <= ST_PWRUP;
            cnt_q   <= '0;
            ch_q    <= start_ch;
            code_q  <= '0;
          end
        end
        ST_PWRUP: begin
          if (pd_last) begin
            state_q <= ST_SAMPLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + TW'(1);
          end
        end
        ST_SAMPLE: begin
          if (smp_last) begin
            state_q <= ST_CONVERT;
            cnt_q   <= '0;
            bit_q   <= TOP_BIT;
          end else begin
            cnt_q <= cnt_q + TW'(1);
          end
        end
        ST_CONVERT: begin
          if (cmp_hi) code_q <= trial;
          if (bit_q == '0) state_q <= ST_STORE;
          else             bit_q   <= bit_q - BW'(1);
        end
        ST_STORE: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign sel_ch     = ch_q;
  assign dac_code   = (state_q == ST_CONVERT) ? trial : '0;
  assign store_we   = (state_q == ST_STORE);
  assign store_ch   = ch_q;
  assign store_data = code_q;

  // The sequencer leaves idle only on a start request from the registers.
  AST_RISE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start_req)); // R3

  // Once running, the converted channel does not move.
  AST_CH_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(ch_q)); // R3

  // The search ends in the store step, never straight back to idle.
  AST_STORE_AFTER_SEARCH: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONVERT && bit_q == '0) |=> store_we); // R6

endmodule

// File: rtl/adcseq_bank.sv
module adcseq_bank #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3,
  parameter int RES_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CH_W-1:0]  wch,
  input  logic [RES_W-1:0] wdata,
  input  logic             rd_en,
  input  logic [CH_W-1:0]  rch,
  output logic [RES_W-1:0] rd_data,
  output logic             rd_valid
);

  // Storage without reset, so it maps to RAM; a reset-able valid bit per slot.
  logic [RES_W-1:0] mem [NUM_CH];
  logic [NUM_CH-1:0] vld_q;
  logic              rch_ok;

  assign rch_ok = (int'(rch) < NUM_CH);

  always_ff @(posedge clk) begin
    if (we) mem[wch] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     vld_q <= '0;
    else if (we) vld_q[wch] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rch];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_valid <= 1'b0;
    else if (rd_en) rd_valid <= rch_ok && vld_q[rch];
  end

  // A slot never holds data right after reset.
  AST_VALID_CLEARED: assert property (@(posedge clk)
    $past(rst) |-> (vld_q == '0)); // R9

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 12,
  parameter int TW     = 16,
  parameter int ADDR_W = 12,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [CH_W-1:0]   ana_sel,
  output logic [RES_W-1:0]  dac_code,
  input  logic              cmp_hi
);

  localparam logic [ADDR_W-1:0] RES_BASE = ADDR_W'(OFS_RES);

  logic              start_req, busy, irq_en, irq_pend, store_we;
  logic [CH_W-1:0]   start_ch, store_ch;
  logic [TW-1:0]     pd_len, smp_len;
  logic [RES_W-1:0]  store_data, bank_data;
  logic              bank_vld;
  logic [31:0]       reg_rd;
  logic [ADDR_W-1:0] res_off;
  logic              res_hit, sel_bank_q, irq_q;

  assign res_off = bus_addr - RES_BASE;
  assign res_hit = (bus_addr >= RES_BASE) && (res_off[1:0] == 2'b00) &&
                   (int'(res_off[ADDR_W-1:2]) < NUM_CH);

  adcseq_regs #(.CH_W(CH_W), .TW(TW), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (bus_wr),
    .rd_en      (bus_rd),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .busy       (busy),
    .store_done (store_we),
    .start_req  (start_req),
    .start_ch   (start_ch),
    .pd_len     (pd_len),
    .smp_len    (smp_len),
    .irq_en     (irq_en),
    .irq_pend   (irq_pend),
    .rd_q       (reg_rd)
  );

  adcseq_fsm #(.CH_W(CH_W), .TW(TW), .RES_W(RES_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .start_ch   (start_ch),
    .pd_len     (pd_len),
    .smp_len    (smp_len),
    .cmp_hi     (cmp_hi),
    .busy       (busy),
    .sel_ch     (ana_sel),
    .dac_code   (dac_code),
    .store_we   (store_we),
    .store_ch   (store_ch),
    .store_data (store_data)
  );

  adcseq_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W), .RES_W(RES_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .we       (store_we),
    .wch      (store_ch),
    .wdata    (store_data),
    .rd_en    (bus_rd && res_hit),
    .rch      (res_off[CH_W+1:2]),
    .rd_data  (bank_data),
    .rd_valid (bank_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_bank_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      sel_bank_q <= bus_rd && res_hit;
      irq_q      <= irq_pend && irq_en;
    end
  end

  assign bus_rdata = sel_bank_q ? (bank_vld ? 32'(bank_data) : 32'h0) : reg_rd;
  assign irq       = irq_q;

  // Storing a result raises the pending flag on the next edge.
  AST_STORE_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
    store_we |=> irq_pend); // R7

  // Armed and pending leads to the interrupt one edge later.
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (irq_pend && irq_en) |=> irq); // R8

  // Without a pending flag the interrupt drops on the next edge.
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !irq_pend |=> !irq); // R8

endmodule

// File: tb/sim_adcseq_top.sv
module sim_adcseq_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [2:0]  ana_sel;
  logic [11:0] dac_code;
  logic        cmp_hi;

  int ana_v [NCH];
  int exp_res [NCH];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_wr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Analog side: comparator answers whether the selected level reaches the trial.
  assign cmp_hi = (ana_v[ana_sel] >= int'(dac_code));

  adcseq_top u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .ana_sel(ana_sel), .dac_code(dac_code), .cmp_hi(cmp_hi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    last_wr = cyc;
  endtask

  task automatic rd(input logic [11:0] a, output int v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = int'(bus_rdata);
  endtask

  task automatic wait_irq(output int at);
    int g = 0;
    while (!irq && g < 4000) begin
      @(negedge clk);
      g++;
    end
    at = cyc;
  endtask

  task automatic check_bank(input string req);
    int v;
    for (int j = 0; j < NCH; j++) begin
      rd(12'h120 + 12'(4*j), v);
      chk(v == exp_res[j], req, v, exp_res[j]);
    end
  endtask

  function automatic int mx1(input int x);
    return (x < 1) ? 1 : x;
  endfunction

  task automatic run_conv(input int ch, input int a, input int pd, input int smp);
    int t0, at, v;
    ana_v[ch] = a;
    wr(12'h004, {16'hFFFF, 16'(pd)});
    wr(12'h00C, {16'hFFFF, 16'(smp)});
    wr(12'h000, {16'h0037, 16'h0030 | 16'(ch)});
    t0 = last_wr;
    wait_irq(at);
    chk(at - t0 == mx1(pd) + mx1(smp) + 14, "R5 latency", at - t0, mx1(pd) + mx1(smp) + 14);
    exp_res[ch] = (a > 4095) ? 4095 : a;
    rd(12'h10C, v);
    chk(v == 0, "R4 idle after store", v, 0);
    wr(12'h110, 32'h1);
    rd(12'h110, v);
    chk(v == 0, "R7 clear by one", v, 0);
    chk(irq == 1'b0, "R8 irq drops", int'(irq), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, t0, at;
    int pats [8] = '{0, 4095, 6000, 2730, 1365, 1, 2048, 2047};
    int regs_a [7] = '{'h000, 'h004, 'h00C, 'h104, 'h108, 'h10C, 'h110};
    for (int j = 0; j < NCH; j++) begin ana_v[j] = 0; exp_res[j] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    chk(irq == 1'b0, "R9 irq after reset", int'(irq), 0);
    foreach (regs_a[i]) begin
      rd(12'(regs_a[i]), v);
      chk(v == 0, "R9 register after reset", v, 0);
    end
    check_bank("R9 results after reset");

    // R1 masked writes
    wr(12'h004, {16'hFFFF, 16'h1234});
    wr(12'h004, {16'h00FF, 16'hABCD});
    rd(12'h004, v);
    chk(v == 'h12CD, "R1 partial mask delay", v, 'h12CD);
    wr(12'h108, {16'hF0F0, 16'hFFFF});
    rd(12'h108, v);
    chk(v == 'hF0F0, "R1 mask spare", v, 'hF0F0);
    wr(12'h108, {16'h00F0, 16'h0000});
    rd(12'h108, v);
    chk(v == 'hF000, "R1 mask clears", v, 'hF000);
    wr(12'h104, {16'h0000, 16'h0001});
    rd(12'h104, v);
    chk(v == 0, "R1 unmasked arm ignored", v, 0);
    wr(12'h00C, {16'h0000, 16'hFFFF});
    rd(12'h00C, v);
    chk(v == 0, "R1 unmasked window ignored", v, 0);

    // R2 field layout, no start
    wr(12'h000, {16'h0027, 16'h0023});
    rd(12'h000, v);
    chk(v == 'h23, "R2 channel and single readback", v, 'h23);
    rd(12'h10C, v);
    chk(v == 0, "R3 no start without go bit", v, 0);

    wr(12'h104, {16'h0001, 16'h0001});

    // Main sweep: R5 R6 over every channel and eight levels
    for (int p = 0; p < 8; p++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        for (int j = 0; j < NCH; j++) if (j != ch) ana_v[j] = 100 * ch + 37 * j + 5;
        run_conv(ch, pats[(p + ch) % 8], (ch + p) % 4, (3 * ch + p) % 5);
        check_bank("R6 result slots");
      end
    end

    rd(12'h000, v);
    chk((v & 'h10) == 0, "R2 start reads zero", v & 'h10, 0);

    // R3 restart while busy; R4 busy; R6 select
    ana_v[2] = 1000;
    ana_v[5] = 3333;
    wr(12'h004, {16'hFFFF, 16'd3});
    wr(12'h00C, {16'hFFFF, 16'd2});
    wr(12'h000, {16'h0037, 16'h0032});
    t0 = last_wr;
    wr(12'h000, {16'h0037, 16'h0035});
    chk(ana_sel == 3'd2, "R6 select shows channel", int'(ana_sel), 2);
    rd(12'h10C, v);
    chk(v == 1, "R4 busy during conversion", v, 1);
    wait_irq(at);
    chk(at - t0 == 3 + 2 + 14, "R3 restart keeps timing", at - t0, 19);
    exp_res[2] = 1000;
    check_bank("R3 restart ignored");
    wr(12'h110, 32'h1);

    // R3 single-shot cleared: nothing launches
    wr(12'h000, {16'h0030, 16'h0010});
    repeat (60) @(negedge clk);
    rd(12'h10C, v);
    chk(v == 0, "R3 single clear no busy", v, 0);
    rd(12'h110, v);
    chk(v == 0, "R3 single clear no pending", v, 0);
    chk(irq == 1'b0, "R3 single clear no irq", int'(irq), 0);

    // R7 R8 unarmed interrupt
    wr(12'h104, {16'h0001, 16'h0000});
    ana_v[1] = 77;
    wr(12'h004, {16'hFFFF, 16'd1});
    wr(12'h00C, {16'hFFFF, 16'd1});
    wr(12'h000, {16'h0037, 16'h0031});
    repeat (40) @(negedge clk);
    chk(irq == 1'b0, "R8 unarmed irq low", int'(irq), 0);
    rd(12'h110, v);
    chk(v == 1, "R7 pending set", v, 1);
    exp_res[1] = 77;
    wr(12'h104, {16'h0001, 16'h0001});
    @(negedge clk);
    chk(irq == 1'b1, "R8 arming raises irq", int'(irq), 1);
    wr(12'h110, 32'h0);
    rd(12'h110, v);
    chk(v == 1, "R7 zero write keeps pending", v, 1);
    wr(12'h110, 32'h1);
    rd(12'h110, v);
    chk(v == 0, "R7 one clears", v, 0);
    check_bank("R6 after unarmed run");

    // R10 unmapped
    rd(12'h008, v);
    chk(v == 0, "R10 hole reads zero", v, 0);
    rd(12'h140, v);
    chk(v == 0, "R10 past last slot", v, 0);
    rd(12'h122, v);
    chk(v == 0, "R10 unaligned slot", v, 0);

    // R9 reset with results present
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk(irq == 1'b0, "R9 irq after second reset", int'(irq), 0);
    for (int j = 0; j < NCH; j++) exp_res[j] = 0;
    check_bank("R9 results cleared");
    foreach (regs_a[i]) begin
      rd(12'(regs_a[i]), v);
      chk(v == 0, "R9 registers cleared", v, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule